// File: doc/BRIEF.md
# Nibble-Serial Firmware Memory Read Target

This block is the target side of a firmware memory read transaction on a 4-bit multiplexed low-pin-count bus. It tracks the active-low frame strobe and the incoming nibble stream. It recognises the start code that marks a firmware read and compares the ID select nibble against a 4-bit strap. When that check passes, it assembles a 28-bit address from seven nibbles.

After the address, the block raises a single-cycle read request to a byte-wide memory port. It then checks the size nibble and waits through the host's half of the bus turnaround. Next it takes the bus and sends a ready sync, followed by the data byte, then drives a turnaround value and releases the bus.

The bidirectional nibble bus is split into three signals: an input, an output and an output enable. The output enable stays low whenever the target does not own the bus.

Top module: `lpc_fw_read_target`

## Requirements
- R1: Every nibble is sampled on the rising clock edge. While `frame_ni` is low, each sampled nibble replaces the candidate start code. The cycle is a firmware read only if the last nibble sampled with `frame_ni` low equals 4'b1101.
- R2: The first nibble sampled with `frame_ni` high is the ID select. If it differs from `id_strap_i`, or the start code was not 4'b1101, the target ignores the rest of the cycle. In that case `lad_oe_o` and `mem_req_o` stay low.
- R3: The next seven nibbles form the address, with bits 27:24 first and bits 3:0 last. The full address appears on `mem_addr_o`.
- R4: `mem_req_o` is high for exactly one cycle, the cycle right after the last address nibble is sampled. `mem_addr_o` holds the full address in that cycle and the next. `mem_rdata_i` is expected one cycle after the request.
- R5: The nibble after the address is the size. If it is not 4'b0000, the target returns to idle and never drives the bus.
- R6: `lad_oe_o` stays low during the host's turnaround cycle. In the following cycle the target drives 4'b1111 with `lad_oe_o` high.
- R7: In the next cycle the target drives a ready sync of 4'b0000 for one cycle.
- R8: The data byte follows over two cycles: bits 3:0 first, then bits 7:4.
- R9: After the data, the target drives 4'b1111 for one cycle. It then holds `lad_oe_o` low, and it is idle again one cycle later.
- R10: Sampling `frame_ni` low in any state aborts the current cycle. The target releases the bus on the next cycle and starts decoding a new start code.
- R11: While `rst_ni` is low, `lad_oe_o` and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_ni | input | 1 | Active-low frame strobe |
| lad_i | input | 4 | Nibble bus, input side |
| lad_o | output | 4 | Nibble bus, output side |
| lad_oe_o | output | 1 | Nibble bus output enable |
| id_strap_i | input | 4 | Strapped target ID |
| mem_req_o | output | 1 | Memory read request, one cycle |
| mem_addr_o | output | 28 | Memory read address |
| mem_rdata_i | input | 8 | Memory read data, valid one cycle after request |

## Verification
The assertions assume that the memory always answers one cycle after a request. They also assume that `frame_ni` is the only thing that can cut a transaction short. The bench meets both conditions: its memory model registers data on every request, and it only aborts a transaction by pulling the strobe low. Random transactions vary the start code, the ID, the size and the number of leading start nibbles. Directed sequences cover an abort during the address phase and an abort while the target owns the bus.

// File: rtl/lpc_fwr_pkg.sv
`timescale 1ns/1ps
package lpc_fwr_pkg;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned BYTE_W = 8;
  localparam logic [NIB_W-1:0] START_FW_READ = 4'b1101;
  localparam logic [NIB_W-1:0] SIZE_ONE_BYTE = 4'b0000;
  localparam logic [NIB_W-1:0] NIB_TURN = 4'b1111;
  localparam logic [NIB_W-1:0] NIB_READY = 4'b0000;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_ADDR,
    ST_SIZE,
    ST_HTAR,   // host turnaround
    ST_TTAR,   // target takes bus
    ST_SYNC,
    ST_DLO,
    ST_DHI,
    ST_RTAR0,
    ST_RTAR1
  } fwr_state_e;
endpackage

// File: rtl/lpc_fwr_seq.sv
`timescale 1ns/1ps
module lpc_fwr_seq
  import lpc_fwr_pkg::*;
#(
  parameter int unsigned ADDR_NIBBLES = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_ni,
  input  logic [NIB_W-1:0] lad_i,
  input  logic [NIB_W-1:0] id_strap_i,
  output fwr_state_e       state_o,
  output logic             shift_en_o,
  output logic             req_o
);
  localparam int unsigned CW = (ADDR_NIBBLES > 1) ? $clog2(ADDR_NIBBLES) : 1;
  localparam logic [CW-1:0] LAST_NIB = CW'(ADDR_NIBBLES - 1);

  fwr_state_e    state_q;
  logic          start_ok_q;
  logic [CW-1:0] nib_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      start_ok_q <= 1'b0;
      nib_cnt_q  <= '0;
    end else if (!frame_ni) begin
      // latest nibble under the strobe wins
      state_q    <= ST_START;
      start_ok_q <= (lad_i == START_FW_READ);
      nib_cnt_q  <= '0;
    end else begin
      unique case (state_q)
        ST_START: state_q <= (start_ok_q && lad_i == id_strap_i) ? ST_ADDR : ST_IDLE;
        ST_ADDR: begin
          nib_cnt_q <= nib_cnt_q + 1'b1;
          if (nib_cnt_q == LAST_NIB) state_q <= ST_SIZE;
        end
        ST_SIZE:  state_q <= (lad_i == SIZE_ONE_BYTE) ? ST_HTAR : ST_IDLE;
        ST_HTAR:  state_q <= ST_TTAR;
        ST_TTAR:  state_q <= ST_SYNC;
        ST_SYNC:  state_q <= ST_DLO;
        ST_DLO:   state_q <= ST_DHI;
        ST_DHI:   state_q <= ST_RTAR0;
        ST_RTAR0: state_q <= ST_RTAR1;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o    = state_q;
  assign shift_en_o = (state_q == ST_ADDR);
  assign req_o      = (state_q == ST_SIZE);

  assert_addr_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADDR && frame_ni && nib_cnt_q != LAST_NIB) |=> state_q == ST_ADDR);
  assert_req_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);
endmodule

// File: rtl/lpc_fwr_addr_cap.sv
`timescale 1ns/1ps
module lpc_fwr_addr_cap
  import lpc_fwr_pkg::*;
#(
  parameter int unsigned ADDR_NIBBLES = 7
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          shift_en_i,
  input  logic [NIB_W-1:0]              lad_i,
  output logic [ADDR_NIBBLES*NIB_W-1:0] addr_o
);
  localparam int unsigned AW = ADDR_NIBBLES * NIB_W;

  logic [AW-1:0] addr_q;

  generate
    if (ADDR_NIBBLES > 1) begin : g_shift
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         addr_q <= '0;
        else if (shift_en_i) addr_q <= {addr_q[AW-NIB_W-1:0], lad_i};
      end
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         addr_q <= '0;
        else if (shift_en_i) addr_q <= lad_i;
      end
    end
  endgenerate

  assign addr_o = addr_q;
endmodule

// File: rtl/lpc_fwr_lad_drive.sv
`timescale 1ns/1ps
module lpc_fwr_lad_drive
  import lpc_fwr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  fwr_state_e        state_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic [NIB_W-1:0]  lad_o,
  output logic              lad_oe_o
);
  logic [BYTE_W-1:0] data_q;

  // memory answers during host turnaround
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  data_q <= '0;
    else if (state_i == ST_HTAR)  data_q <= rdata_i;
  end

  always_comb begin
    lad_o    = NIB_TURN;
    lad_oe_o = 1'b1;
    unique case (state_i)
      ST_TTAR:  lad_o = NIB_TURN;
      ST_SYNC:  lad_o = NIB_READY;
      ST_DLO:   lad_o = data_q[NIB_W-1:0];
      ST_DHI:   lad_o = data_q[BYTE_W-1:NIB_W];
      ST_RTAR0: lad_o = NIB_TURN;
      default:  lad_oe_o = 1'b0;
    endcase
  end

  assert_data_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_DLO) |=> $stable(data_q));
endmodule

// File: rtl/lpc_fw_read_target.sv
`timescale 1ns/1ps
module lpc_fw_read_target
  import lpc_fwr_pkg::*;
#(
  parameter int unsigned ADDR_NIBBLES = 7,
  localparam int unsigned AW = ADDR_NIBBLES * 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_ni,
  input  logic [3:0]    lad_i,
  output logic [3:0]    lad_o,
  output logic          lad_oe_o,
  input  logic [3:0]    id_strap_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [7:0]    mem_rdata_i
);
  fwr_state_e state;
  logic       shift_en;

  lpc_fwr_seq #(.ADDR_NIBBLES(ADDR_NIBBLES)) u_seq (
    .clk_i, .rst_ni, .frame_ni, .lad_i, .id_strap_i,
    .state_o(state), .shift_en_o(shift_en), .req_o(mem_req_o)
  );

  lpc_fwr_addr_cap #(.ADDR_NIBBLES(ADDR_NIBBLES)) u_addr (
    .clk_i, .rst_ni, .shift_en_i(shift_en), .lad_i, .addr_o(mem_addr_o)
  );

  lpc_fwr_lad_drive u_drive (
    .clk_i, .rst_ni, .state_i(state), .rdata_i(mem_rdata_i),
    .lad_o, .lad_oe_o
  );

  assert_take_after_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lad_oe_o) |-> $past(mem_req_o, 2) && $past(!lad_oe_o));
  assert_addr_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> $stable(mem_addr_o));
  assert_sync_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lad_oe_o) |=> (!$past(frame_ni) || (lad_oe_o && lad_o == NIB_READY)));
  assert_release_turn_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(lad_oe_o) && $past(frame_ni)) |-> $past(lad_o) == NIB_TURN);
  assert_abort_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_ni |=> !lad_oe_o && !mem_req_o);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) assert_reset_quiet_R11: assert (!lad_oe_o && !mem_req_o);
  end
endmodule

// File: tb/lpc_fw_read_target_tb.sv
`timescale 1ns/1ps
module lpc_fw_read_target_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_ni = 1'b1;
  logic [3:0]  lad_i = 4'hF;
  logic [3:0]  lad_o;
  logic        lad_oe_o;
  logic [3:0]  id_strap_i = 4'h0;
  logic        mem_req_o;
  logic [27:0] mem_addr_o;
  logic [7:0]  mem_rdata_i = 8'h00;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  lpc_fw_read_target dut_i (
    .clk_i, .rst_ni, .frame_ni, .lad_i, .lad_o, .lad_oe_o,
    .id_strap_i, .mem_req_o, .mem_addr_o, .mem_rdata_i
  );

  function automatic logic [7:0] mem_fn(input logic [27:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ {a[27:24], a[3:0]} ^ 8'h5A;
  endfunction

  // one-cycle latency memory
  always @(posedge clk_i) if (mem_req_o) mem_rdata_i <= mem_fn(mem_addr_o);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic f, input logic [3:0] l);
    frame_ni = f;
    lad_i = l;
    @(negedge clk_i);
  endtask

  task automatic xact(input int npre, input logic [3:0] start, input logic [3:0] id,
                      input logic [27:0] addr, input logic [3:0] size);
    bit hit, ok;
    logic [7:0] d;
    hit = (start == 4'hD) && (id == id_strap_i);
    ok = hit && (size == 4'h0);
    d = mem_fn(addr);
    for (int i = 0; i < npre; i++) drive(1'b0, 4'(i * 3 + 1));
    drive(1'b0, start);
    chk(lad_oe_o, 0, "R1 oe during start");
    drive(1'b1, id);
    chk(lad_oe_o, 0, "R2 oe after id");
    for (int i = 6; i >= 0; i--) begin
      drive(1'b1, addr[i*4 +: 4]);
      if (i > 0) chk(mem_req_o, 0, "R4 no early req");
    end
    chk(mem_req_o, hit, "R2 R4 req after addr");
    if (hit) chk(mem_addr_o, addr, "R3 address");
    drive(1'b1, size);
    chk(mem_req_o, 0, "R4 req one cycle");
    if (hit) chk(mem_addr_o, addr, "R4 addr held");
    chk(lad_oe_o, 0, "R6 host turnaround");
    drive(1'b1, 4'hF);
    chk(lad_oe_o, ok, "R5 R6 target takes bus");
    if (ok) chk(lad_o, 4'hF, "R6 turn value");
    drive(1'b1, 4'hF);
    chk(lad_oe_o, ok, "R7 sync oe");
    if (ok) chk(lad_o, 4'h0, "R7 sync ready");
    drive(1'b1, 4'hF);
    if (ok) chk(lad_o, d[3:0], "R8 low nibble");
    chk(lad_oe_o, ok, "R8 oe lo");
    drive(1'b1, 4'hF);
    if (ok) chk(lad_o, d[7:4], "R8 high nibble");
    drive(1'b1, 4'hF);
    chk(lad_oe_o, ok, "R9 end turn oe");
    if (ok) chk(lad_o, 4'hF, "R9 end turn value");
    drive(1'b1, 4'hF);
    chk(lad_oe_o, 0, "R9 released");
    drive(1'b1, 4'hF);
    chk(lad_oe_o, 0, "R9 idle");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    id_strap_i = 4'h6;
    repeat (2) @(negedge clk_i);
    chk(lad_oe_o, 0, "R11 oe in reset");
    chk(mem_req_o, 0, "R11 req in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);

    // directed
    xact(0, 4'hD, 4'h6, 28'h89ABCDE, 4'h0);
    xact(2, 4'hD, 4'h6, 28'h0000000, 4'h0);       // R1 last start nibble counts
    xact(0, 4'hD, 4'h6, 28'hFFFFFFF, 4'h0);
    xact(0, 4'hD, 4'h5, 28'h1234567, 4'h0);       // R2 id mismatch
    xact(0, 4'hD, 4'h6, 28'h1234567, 4'h1);       // R5 bad size
    // R1: valid code followed by another nibble under the strobe
    drive(1'b0, 4'hD);
    xact(0, 4'h2, 4'h6, 28'h7654321, 4'h0);

    // R10 abort in address phase
    drive(1'b0, 4'hD); drive(1'b1, 4'h6);
    drive(1'b1, 4'h3); drive(1'b1, 4'h4); drive(1'b1, 4'h5);
    xact(0, 4'hD, 4'h6, 28'hA5A5A5A, 4'h0);

    // R10 abort while target owns the bus
    drive(1'b0, 4'hD); drive(1'b1, 4'h6);
    for (int i = 0; i < 7; i++) drive(1'b1, 4'h1);
    drive(1'b1, 4'h0); drive(1'b1, 4'hF); drive(1'b1, 4'hF);
    chk(lad_oe_o, 1, "R10 owning before abort");
    drive(1'b0, 4'h0);
    chk(lad_oe_o, 0, "R10 released on abort");
    xact(0, 4'hD, 4'h6, 28'h0F0F0F0, 4'h0);

    // random
    for (int n = 0; n < 200; n++) begin
      logic [3:0] st, id, sz;
      logic [27:0] ad;
      id_strap_i = 4'($urandom);
      st = ($urandom % 8 == 0) ? 4'($urandom) : 4'hD;
      id = ($urandom % 4 == 0) ? 4'($urandom) : id_strap_i;
      sz = ($urandom % 8 == 0) ? 4'($urandom) : 4'h0;
      ad = 28'($urandom);
      xact($urandom % 3, st, id, ad, sz);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule